// File: doc/BRIEF.md
# ADC Interrupt and Status Controller

This block keeps the two status flags that describe the state of an ADC result register: a "result ready" flag and an "overrun" flag. It also produces a single interrupt request from them. The converter pulses a write strobe each time it stores a new 12-bit result. The bus side pulses one strobe when software reads the result register and another when software reads the status register.

The two flags are cleared by different reads. Reading the result clears only the ready flag. Reading the status clears only the overrun flag. An overrun is recorded when a new result arrives while the ready flag still shows an unread value.

Each flag reaches the interrupt line only when its own enable bit is set. Both are then gated by a module mask bit and a global enable bit. The request is a level: it stays asserted for as long as an enabled flag remains set and both gates are open.

Top module: `adc_irq_ctrl`

## Requirements
- R1: A cycle with `res_wr`=1 leaves `rdy_flag`=1 after the next rising clock edge, unless R6 applies.
- R2: A cycle with `data_rd`=1 and `res_wr`=0 leaves `rdy_flag`=0 after the next edge.
- R3: A cycle with `res_wr`=1, `rdy_flag`=1 and `data_rd`=0 leaves `ovr_flag`=1 after the next edge.
- R4: `ovr_flag` is cleared only by a cycle with `stat_rd`=1; a `data_rd` pulse alone leaves it unchanged.
- R5: `stat_rd` has no effect on `rdy_flag`.
- R6: When `res_wr` and `data_rd` are both 1 in the same cycle, `rdy_flag` stays 1 and no overrun is recorded.
- R7: When an overrun condition (R3) and `stat_rd`=1 occur in the same cycle, `ovr_flag` is 1 after the edge.
- R8: Each flag contributes to `irq` only while its own enable is 1 (`rdy_ie` for ready, `ovr_ie` for overrun); with its enable at 0 the flag still sets.
- R9: `irq` is 0 whenever `mod_mask`=0 or `glb_en`=0, whatever the flags.
- R10: After reset both flags are 0 and `irq` is 0.
- R11: `irq` stays asserted, without further events, for as long as an enabled flag stays set with both gates open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_wr | input | 1 | Converter stored a new result this cycle |
| data_rd | input | 1 | Result register read this cycle |
| stat_rd | input | 1 | Status register read this cycle |
| rdy_ie | input | 1 | Ready-source interrupt enable |
| ovr_ie | input | 1 | Overrun-source interrupt enable |
| mod_mask | input | 1 | Module-level interrupt mask bit (1 = allowed) |
| glb_en | input | 1 | Global interrupt enable bit |
| rdy_flag | output | 1 | Result-ready status flag |
| ovr_flag | output | 1 | Overrun status flag |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest states to reach are those where the overrun flag is set while the ready flag is clear. They are needed to show that a status read does not touch ready and that a result read does not touch overrun. The bench reaches them from reset with two result writes followed by a result read. It then applies every combination of the three strobes from each of the four flag states, including a same-cycle overrun and status read. The interrupt gating is swept across all sixteen enable combinations for each flag state.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

    typedef struct packed {
        logic rdy;
        logic ovr;
    } flag_state_t;

    localparam flag_state_t FLAGS_RESET = '{rdy: 1'b0, ovr: 1'b0};

endpackage

// File: rtl/adc_ready_next.sv
module adc_ready_next (
    input  logic rdy_q,
    input  logic res_wr,
    input  logic data_rd,
    output logic rdy_d
);
    // A fresh result always wins over a read in the same cycle.
    always_comb begin
        rdy_d = rdy_q;
        if (data_rd) rdy_d = 1'b0;
        if (res_wr)  rdy_d = 1'b1;
    end
endmodule

// File: rtl/adc_overrun_next.sv
module adc_overrun_next (
    input  logic ovr_q,
    input  logic rdy_q,
    input  logic res_wr,
    input  logic data_rd,
    input  logic stat_rd,
    output logic ovr_d
);
    logic lost_result;

    always_comb begin
        // Unread data is the ready flag; a read in the same cycle consumes it.
        lost_result = res_wr & rdy_q & ~data_rd;
        ovr_d       = ovr_q;
        if (stat_rd)     ovr_d = 1'b0;
        if (lost_result) ovr_d = 1'b1;
    end
endmodule

// File: rtl/adc_irq_gate.sv
module adc_irq_gate #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] src_flag,
    input  logic [N_SRC-1:0] src_en,
    input  logic             mod_mask,
    input  logic             glb_en,
    output logic             irq
);
    logic any_src;

    always_comb begin
        any_src = |(src_flag & src_en);
        irq     = any_src & mod_mask & glb_en;
    end
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl
    import adc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_wr,
    input  logic data_rd,
    input  logic stat_rd,
    input  logic rdy_ie,
    input  logic ovr_ie,
    input  logic mod_mask,
    input  logic glb_en,
    output logic rdy_flag,
    output logic ovr_flag,
    output logic irq
);
    localparam int N_SRC = 2;

    flag_state_t state_d, state_q;
    logic        rdy_nx, ovr_nx;

    adc_ready_next u_rdy (
        .rdy_q   (state_q.rdy),
        .res_wr  (res_wr),
        .data_rd (data_rd),
        .rdy_d   (rdy_nx)
    );

    adc_overrun_next u_ovr (
        .ovr_q   (state_q.ovr),
        .rdy_q   (state_q.rdy),
        .res_wr  (res_wr),
        .data_rd (data_rd),
        .stat_rd (stat_rd),
        .ovr_d   (ovr_nx)
    );

    always_comb begin
        state_d     = state_q;
        state_d.rdy = rdy_nx;
        state_d.ovr = ovr_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAGS_RESET;
        else        state_q <= state_d;
    end

    adc_irq_gate #(.N_SRC(N_SRC)) u_gate (
        .src_flag ({state_q.ovr, state_q.rdy}),
        .src_en   ({ovr_ie, rdy_ie}),
        .mod_mask (mod_mask),
        .glb_en   (glb_en),
        .irq      (irq)
    );

    assign rdy_flag = state_q.rdy;
    assign ovr_flag = state_q.ovr;
endmodule

// File: rtl/adc_irq_ctrl_chk.sv
module adc_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic res_wr,
    input logic data_rd,
    input logic stat_rd,
    input logic rdy_ie,
    input logic ovr_ie,
    input logic mod_mask,
    input logic glb_en,
    input logic rdy_flag,
    input logic ovr_flag,
    input logic irq
);
    AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> rdy_flag); // R1
    AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !res_wr) |=> !rdy_flag); // R2
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr && rdy_flag && !data_rd) |=> ovr_flag); // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !stat_rd) |=> ovr_flag); // R4
    AST_STAT_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !res_wr && !data_rd) |=> $stable(rdy_flag)); // R5
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr && data_rd && !ovr_flag) |=> (rdy_flag && !ovr_flag)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr && rdy_flag && !data_rd && stat_rd) |=> ovr_flag); // R7
    AST_SRC_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rdy_flag && rdy_ie) || (ovr_flag && ovr_ie))); // R8
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_mask || !glb_en) |-> !irq); // R9
endmodule

bind adc_irq_ctrl adc_irq_ctrl_chk u_chk (.*);

// File: tb/adc_irq_ctrl_test.sv
module adc_irq_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_wr = 0, data_rd = 0, stat_rd = 0;
    logic rdy_ie = 0, ovr_ie = 0, mod_mask = 0, glb_en = 0;
    logic rdy_flag, ovr_flag, irq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_irq_ctrl uut (.*);

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // One clock with the given strobes; outputs sampled 1 ns after the edge.
    task automatic step(logic w, logic dr, logic sr);
        @(negedge clk);
        res_wr = w; data_rd = dr; stat_rd = sr;
        @(posedge clk);
        #1;
        @(negedge clk);
        res_wr = 0; data_rd = 0; stat_rd = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1;
    endtask

    // Reach a flag state (r, o) from reset through the ports only.
    task automatic reach(logic r, logic o);
        do_reset();
        if (o) begin
            step(1, 0, 0);
            step(1, 0, 0);
            if (!r) step(0, 1, 0);
        end else if (r) begin
            step(1, 0, 0);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        #2;
        check("R10", rdy_flag, 1'b0, "ready after reset");
        check("R10", ovr_flag, 1'b0, "overrun after reset");
        check("R10", irq, 1'b0, "irq after reset");

        // Flag transitions: every start state times every strobe pattern.
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 8; p++) begin
                logic r0, o0, w, dr, sr, er, eo, lost;
                string tr, to;
                r0 = s[0]; o0 = s[1];
                w = p[0]; dr = p[1]; sr = p[2];
                reach(r0, o0);
                check("R10", {rdy_flag, ovr_flag} == {r0, o0}, 1'b1, "state setup");
                lost = w & r0 & ~dr;
                er = w ? 1'b1 : (dr ? 1'b0 : r0);
                eo = lost ? 1'b1 : (sr ? 1'b0 : o0);
                if (w && dr)      tr = "R6";
                else if (w)       tr = "R1";
                else if (dr)      tr = "R2";
                else              tr = "R5";
                if (lost && sr)   to = "R7";
                else if (lost)    to = "R3";
                else if (w && dr) to = "R6";
                else              to = "R4";
                @(negedge clk);
                res_wr = w; data_rd = dr; stat_rd = sr;
                @(negedge clk);
                res_wr = 0; data_rd = 0; stat_rd = 0;
                check(tr, rdy_flag, er, $sformatf("ready s=%0d p=%0d", s, p));
                check(to, ovr_flag, eo, $sformatf("overrun s=%0d p=%0d", s, p));
            end
        end

        // Interrupt gating: every flag state times every enable pattern.
        for (int s = 0; s < 4; s++) begin
            logic r0, o0;
            r0 = s[0]; o0 = s[1];
            reach(r0, o0);
            for (int e = 0; e < 16; e++) begin
                logic exp_irq;
                @(negedge clk);
                rdy_ie = e[0]; ovr_ie = e[1]; mod_mask = e[2]; glb_en = e[3];
                #2;
                exp_irq = ((r0 & e[0]) | (o0 & e[1])) & e[2] & e[3];
                check((e[2] && e[3]) ? "R8" : "R9", irq, exp_irq,
                      $sformatf("irq s=%0d e=%0d", s, e));
            end
        end

        // Level hold: the request stays up with no further events.
        reach(1'b0, 1'b1);
        @(negedge clk);
        rdy_ie = 0; ovr_ie = 1; mod_mask = 1; glb_en = 1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R11", irq, 1'b1, "irq held while overrun pending");
        end
        step(0, 1, 0);
        check("R4", ovr_flag, 1'b1, "result read leaves overrun");
        check("R11", irq, 1'b1, "irq held after result read");
        step(0, 0, 1);
        check("R11", irq, 1'b0, "irq drops after status read");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule